// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block gathers the data bytes of one serial-memory write session into a 32-entry staging buffer and then commits them to a 4096 x 8 byte store in one timed write cycle. A protocol front end opens a session with a start strobe and a 12-bit target address. It hands over data bytes one per strobe and closes the session with a stop strobe, or drops it with an abort. The upper address bits pick a 32-byte page, and that page is held for the whole session. The lower five bits give the first offset, which advances and wraps inside the page.

On stop, the buffer writes only the offsets that received data. All of them go out in one fixed-length cycle. A busy flag covers that whole cycle, so the front end can refuse (not acknowledge) new requests. The store has its own registered read port. Every location reads as 0xFF until it is first written.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy is low, mem_we is low, and every store address reads as 0xFF.
- R2: A start strobe latches address bits [11:5] as the page and bits [4:0] as the first offset. It discards any uncommitted bytes of an earlier session.
- R3: Each accepted byte goes to the current offset, and the offset then advances by one modulo 32. A byte loaded at offset 31 is followed by offset 0 of the same page.
- R4: A byte loaded to an offset already loaded in the same session replaces the earlier value.
- R5: A stop strobe on an open session holding at least one byte raises busy on the next clock edge. Busy then stays high for exactly CYCLE_CLKS clocks.
- R6: After the cycle, each loaded offset of the page holds its last loaded byte. Every offset that was not loaded keeps its previous value.
- R7: A stop on a session with no bytes starts no cycle and leaves busy low. So does a stop that follows an abort, or a start that follows the data it replaced. Discarded bytes never reach the store.
- R8: While busy is high, start, byte, stop and abort strobes are all ignored. A stop after the cycle therefore finds no open session.
- R9: rd_data shows the store content at rd_addr one clock after rd_addr is presented.
- R10: mem_we pulses only while busy is high. It pulses at most 32 times per cycle, and every pulse in one cycle addresses the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_start | input | 1 | Opens a session at sess_addr |
| sess_addr | input | 12 | Session start address: page in [11:5], offset in [4:0] |
| byte_vld | input | 1 | One data byte is offered |
| byte_data | input | 8 | Data byte |
| stop_cmt | input | 1 | Closes the session and commits its bytes |
| abort | input | 1 | Drops the open session |
| rd_addr | input | 12 | Read port address |
| busy | output | 1 | High for the whole write cycle |
| mem_we | output | 1 | Store write strobe |
| mem_waddr | output | 12 | Store write address |
| mem_wdata | output | 8 | Store write data |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions check on every cycle that writes to the store happen only inside a busy window and never more than 32 per window. They also check that all writes in a window stay in one page, that busy rises only after a stop, and that each busy window lasts exactly CYCLE_CLKS clocks. Several behaviours can only be shown by the bench's scenarios against a reference model of the store: the in-page wrap, overwrite within a session, preservation of offsets that were not loaded, the discarding of aborted or replaced sessions, and the ignoring of strobes during busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic {
        SESS_IDLE = 1'b0,
        SESS_OPEN = 1'b1
    } sess_e;

    localparam byte_t ERASED = 8'hFF;
endpackage

// File: rtl/pwb_collect.sv
module pwb_collect
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     busy_i,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     vld_i,
    input  byte_t                    data_i,
    input  logic                     cmt_i,
    input  logic                     abort_i,
    input  logic [OFF_W-1:0]         scan_off_i,
    output logic                     go_o,
    output logic [ADDR_W-OFF_W-1:0]  page_o,
    output logic [(1<<OFF_W)-1:0]    mask_o,
    output byte_t                    scan_byte_o
);
    localparam int PAGE_N = 1 << OFF_W;
    localparam int PG_W   = ADDR_W - OFF_W;

    typedef struct packed {
        sess_e             st;
        logic [PG_W-1:0]   page;
        logic [OFF_W-1:0]  off;
        logic [PAGE_N-1:0] mask;
    } coll_t;

    coll_t s_d, s_q;
    byte_t dat_d [PAGE_N];
    byte_t dat_q [PAGE_N];
    logic  go_d;

    always_comb begin
        s_d   = s_q;
        dat_d = dat_q;
        go_d  = 1'b0;
        if (!busy_i) begin
            if (abort_i) begin
                s_d.st   = SESS_IDLE;
                s_d.mask = '0;
            end else if (start_i) begin
                s_d.st   = SESS_OPEN;
                s_d.page = addr_i[ADDR_W-1:OFF_W];
                s_d.off  = addr_i[OFF_W-1:0];
                s_d.mask = '0;
            end else if (s_q.st == SESS_OPEN) begin
                if (cmt_i) begin
                    s_d.st = SESS_IDLE;
                    go_d   = |s_q.mask;
                end else if (vld_i) begin
                    dat_d[s_q.off]  = data_i;
                    s_d.mask[s_q.off] = 1'b1;
                    s_d.off         = s_q.off + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SESS_IDLE, page: '0, off: '0, mask: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

    assign go_o        = go_d;
    assign page_o      = s_q.page;
    assign mask_o      = s_q.mask;
    assign scan_byte_o = dat_q[scan_off_i];
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
    parameter int CYCLE_CLKS = 500,
    parameter int OFF_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    output logic             busy_o,
    output logic [OFF_W-1:0] scan_off_o,
    output logic             scan_vld_o
);
    localparam int PAGE_N = 1 << OFF_W;
    localparam int CW     = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 2;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] el;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.el == CW'(CYCLE_CLKS - 1)) begin
                s_d.busy = 1'b0;
                s_d.el   = '0;
            end else begin
                s_d.el = s_q.el + 1'b1;
            end
        end else if (go_i) begin
            s_d.busy = 1'b1;
            s_d.el   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, el: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign scan_off_o = s_q.el[OFF_W-1:0];
    assign scan_vld_o = s_q.busy && (32'(s_q.el) < PAGE_N);
endmodule

// File: rtl/pwb_array.sv
module pwb_array
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  byte_t             wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output byte_t             rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0] filled;
        byte_t            rd;
    } arr_t;

    arr_t  s_d, s_q;
    byte_t mem_q [DEPTH];

    always_comb begin
        s_d    = s_q;
        s_d.rd = s_q.filled[raddr_i] ? mem_q[raddr_i] : ERASED;
        if (we_i) begin
            s_d.filled[waddr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{filled: '0, rd: ERASED};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = s_q.rd;
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int OFF_W      = 5,
    parameter int CYCLE_CLKS = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic [ADDR_W-1:0] sess_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              stop_cmt,
    input  logic              abort,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [7:0]        rd_data
);
    localparam int PAGE_N = 1 << OFF_W;
    localparam int PG_W   = ADDR_W - OFF_W;

    logic              go;
    logic [PG_W-1:0]   page;
    logic [PAGE_N-1:0] mask;
    byte_t             scan_byte;
    logic [OFF_W-1:0]  scan_off;
    logic              scan_vld;
    logic              busy_int;

    pwb_collect #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) collect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_int),
        .start_i    (sess_start),
        .addr_i     (sess_addr),
        .vld_i      (byte_vld),
        .data_i     (byte_data),
        .cmt_i      (stop_cmt),
        .abort_i    (abort),
        .scan_off_i (scan_off),
        .go_o       (go),
        .page_o     (page),
        .mask_o     (mask),
        .scan_byte_o(scan_byte)
    );

    pwb_commit_seq #(.CYCLE_CLKS(CYCLE_CLKS), .OFF_W(OFF_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .busy_o    (busy_int),
        .scan_off_o(scan_off),
        .scan_vld_o(scan_vld)
    );

    assign busy      = busy_int;
    assign mem_we    = scan_vld && mask[scan_off];
    assign mem_waddr = {page, scan_off};
    assign mem_wdata = scan_byte;

    pwb_array #(.ADDR_W(ADDR_W)) array_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mem_we),
        .waddr_i(mem_waddr),
        .wdata_i(mem_wdata),
        .raddr_i(rd_addr),
        .rdata_o(rd_data)
    );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W     = 12,
    parameter int OFF_W      = 5,
    parameter int CYCLE_CLKS = 500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_cmt,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    localparam int PAGE_N = 1 << OFF_W;
    localparam int RW     = $clog2(CYCLE_CLKS + 1) + 1;

    logic [RW-1:0]    run_len;
    logic [OFF_W+1:0] we_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            we_cnt  <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            we_cnt  <= busy ? we_cnt + RW'(mem_we) : '0;
        end
    end

    // R10
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R10
    we_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(we_cnt) < PAGE_N));

    // R10
    same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && busy && $past(busy) && $past(mem_we))
            |-> (mem_waddr[ADDR_W-1:OFF_W] == $past(mem_waddr[ADDR_W-1:OFF_W])));

    // R5
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_cmt));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (32'(run_len) == CYCLE_CLKS));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(run_len) < CYCLE_CLKS));
endmodule

bind page_write_buffer pwb_checker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CYCLE_CLKS(CYCLE_CLKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_cmt (stop_cmt),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr)
);

// File: tb/page_write_buffer_tb_top.sv
`timescale 1ns/1ps
module page_write_buffer_tb_top;
    localparam int CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sess_start = 1'b0;
    logic [11:0] sess_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_cmt = 1'b0;
    logic        abort = 1'b0;
    logic [11:0] rd_addr = '0;
    logic        busy, mem_we;
    logic [11:0] mem_waddr;
    logic [7:0]  mem_wdata, rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] ref_mem [4096];
    logic [7:0] m_buf [32];
    logic [31:0] m_mask;
    logic [6:0] m_page;
    logic [4:0] m_off;
    bit         m_open;

    always #5 clk = ~clk;

    page_write_buffer #(.ADDR_W(12), .OFF_W(5), .CYCLE_CLKS(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_addr(sess_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_cmt(stop_cmt), .abort(abort),
        .rd_addr(rd_addr), .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [11:0] a);
        return ref_mem[a];
    endfunction

    task automatic op_start(input logic [11:0] a);
        sess_start = 1'b1; sess_addr = a;
        @(negedge clk);
        sess_start = 1'b0;
        m_open = 1'b1; m_page = a[11:5]; m_off = a[4:0]; m_mask = '0;
    endtask

    task automatic op_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0;
        if (m_open) begin
            m_buf[m_off] = d; m_mask[m_off] = 1'b1; m_off = m_off + 1'b1;
        end
    endtask

    task automatic op_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        m_open = 1'b0; m_mask = '0;
    endtask

    task automatic op_commit(input bit junk, input string tag);
        bit expect_run;
        int n;
        expect_run = m_open && (m_mask != 0);
        stop_cmt = 1'b1;
        @(negedge clk);
        stop_cmt = 1'b0;
        if (expect_run) begin
            chk(busy == 1'b1, "R5 busy rise", busy, 1);
            n = 1;
            while (busy && n < CYC + 10) begin
                if (junk) begin
                    sess_start = 1'b1; sess_addr = 12'($urandom);
                    byte_vld = 1'b1; byte_data = 8'($urandom);
                    stop_cmt = 1'($urandom); abort = 1'($urandom);
                end
                @(negedge clk);
                sess_start = 1'b0; byte_vld = 1'b0; stop_cmt = 1'b0; abort = 1'b0;
                if (busy) n++;
            end
            chk(n == CYC, "R5 busy length", n, CYC);
            for (int i = 0; i < 32; i++)
                if (m_mask[i]) ref_mem[{m_page, 5'(i)}] = m_buf[i];
        end else begin
            for (int i = 0; i < 3; i++) begin
                chk(busy == 1'b0, tag, busy, 0);
                @(negedge clk);
            end
        end
        m_open = 1'b0;
    endtask

    task automatic chk_read(input logic [11:0] a, input string tag);
        rd_addr = a;
        @(negedge clk);
        chk(rd_data == exp_rd(a), tag, rd_data, exp_rd(a));
    endtask

    task automatic chk_page(input logic [6:0] p, input string tag);
        for (int i = 0; i < 32; i++) chk_read({p, 5'(i)}, tag);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) ref_mem[i] = 8'hFF;
        m_open = 1'b0; m_mask = '0; m_page = '0; m_off = '0;
        for (int i = 0; i < 32; i++) m_buf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
        chk_read(12'h000, "R1 erased");
        chk_read(12'hFFF, "R1 erased");
        chk_read(12'h7A3, "R1 erased");

        // R2: single byte at last offset of a page
        op_start(12'h35F);
        op_byte(8'h5A);
        op_commit(1'b0, "R2");
        chk_page(7'h1A, "R2 single byte");
        chk_read(12'h360, "R2 next page untouched");

        // R3: wrap from offset 30
        op_start({7'h22, 5'd30});
        for (int i = 0; i < 5; i++) op_byte(8'h10 + 8'(i));
        op_commit(1'b0, "R3");
        chk_read({7'h22, 5'd31}, "R3 offset31");
        chk_read({7'h22, 5'd0}, "R3 wrap offset0");
        chk_read({7'h22, 5'd2}, "R3 wrap offset2");
        chk_read({7'h23, 5'd0}, "R3 no spill");
        chk_page(7'h22, "R6 partial page");

        // R4: 40 bytes overwrite the first 8 offsets loaded
        op_start({7'h05, 5'd3});
        for (int i = 0; i < 40; i++) op_byte(8'(i * 3 + 1));
        op_commit(1'b0, "R4");
        chk_read({7'h05, 5'd3}, "R4 overwritten");
        chk_page(7'h05, "R4 page");

        // R7: empty session, abort, replaced session
        op_start(12'h400);
        op_commit(1'b0, "R7 empty session");
        op_start(12'h400);
        op_byte(8'hAA);
        op_abort();
        op_commit(1'b0, "R7 after abort");
        chk_read(12'h400, "R7 abort data discarded");
        op_start(12'h410);
        op_byte(8'hBB);
        op_start(12'h420);
        op_byte(8'hCC);
        op_commit(1'b0, "R7 replaced");
        chk_read(12'h410, "R7 replaced data discarded");
        chk_read(12'h420, "R7 new session written");

        // R8: strobes during busy ignored
        op_start(12'h600);
        op_byte(8'h11);
        op_commit(1'b1, "R8");
        op_commit(1'b0, "R8 stop after busy");
        chk_page(7'h30, "R8 page intact");

        // R9: read latency
        rd_addr = 12'h600;
        @(negedge clk);
        rd_addr = 12'h000;
        chk(rd_data == 8'h11, "R9 read", rd_data, 8'h11);

        // random sessions
        for (int s = 0; s < 25; s++) begin
            logic [11:0] a;
            int nb, r;
            a  = 12'($urandom);
            nb = $urandom_range(0, 45);
            r  = $urandom_range(0, 9);
            op_start(a);
            for (int b = 0; b < nb; b++) op_byte(8'($urandom));
            if (r < 7) begin
                op_commit(r == 0, "R5 random");
            end else if (r < 9) begin
                op_abort();
                op_commit(1'b0, "R7 random abort");
            end else begin
                op_start(a ^ 12'h0A5);
                op_byte(8'($urandom));
                op_byte(8'($urandom));
                op_commit(1'b0, "R7 random restart");
            end
            chk_page(a[11:5], "R6 random page");
            chk_read(12'($urandom), "R6 random addr");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule